// File: doc/BRIEF.md
# Serial Converter Frame Receiver

This block runs a high-speed converter that sends each 16-bit result on one serial data line. When a conversion is requested and the receiver is idle, it raises a convert strobe. It waits a fixed conversion time and then drives a burst of shift clocks. From the data line it assembles a parallel result word, which it presents with a one-cycle valid pulse. No new convert strobe starts until the burst has finished and the word has been reported.

A static mode input picks how bits are captured. In self-clocked mode, before the burst the line holds a leading 0. The first two falling shift-clock edges launch the header bits 1 and then 0, and the result bits follow. The receiver samples the line in the cycle after each falling edge. It judges the word by whether the header sits in its expected slot, and a misplaced or wrong header produces a framing-error pulse instead of a result. In echoed-clock mode, the converter returns a copy of the shift clock. The first result bit is already on the line before the burst, and each bit is captured on a rising edge of the returned clock.

Top module: `adc_frame_rx`

## Requirements
- R1: When `convReq` is high in idle, `cnvOut` rises and stays high for exactly CNV_HIGH (default 2) system cycles. Each conversion raises it exactly once. A request held high through the whole burst starts no second strobe before the word or error is reported.
- R2: `sclkOut` is low outside the burst and is never high while `cnvOut` is high. Each shift pulse is high for one system cycle and low for at least one. A conversion gives 18 pulses with `modeSelf`=1 and 16 pulses with `modeSelf`=0.
- R3: With `modeSelf`=1, the 16 bits launched by falling edges 3 to 18 form `resultWord`, most significant bit first, in two's complement. The line shows 0 before the burst, falling edge 1 launches 1, and falling edge 2 launches 0.
- R4: With `modeSelf`=0, the most significant bit is on `serData` before the burst. Each rising edge of `echoClk` captures one bit, and the 16 captured bits, first bit in the top position, form `resultWord`.
- R5: `resultValid` is high for exactly one system cycle per good word. `resultWord` changes only together with that pulse and holds its value otherwise.
- R6: With `modeSelf`=1, if the two header bits differ from 1 then 0, the word is discarded. `resultValid` stays low, `resultWord` keeps its previous value, and `frameErr` is high for exactly one cycle.
- R7: With `rstN` low at a clock edge, `cnvOut`, `sclkOut`, `resultValid` and `frameErr` are 0 after that edge and `resultWord` is cleared to 0. This also holds when reset arrives in the middle of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| modeSelf | input | 1 | 1 = self-clocked header alignment, 0 = echoed-clock capture; held static |
| convReq | input | 1 | Request to start a conversion |
| serData | input | 1 | Serial data from the converter |
| echoClk | input | 1 | Shift clock returned by the converter (echoed-clock mode) |
| cnvOut | output | 1 | Convert strobe; conversion starts on its rising edge |
| sclkOut | output | 1 | Shift clock to the converter |
| resultWord | output | 16 | Last good result, two's complement |
| resultValid | output | 1 | One-cycle pulse with a new result |
| frameErr | output | 1 | One-cycle pulse on a bad header |

## Verification
Some properties are checked on every cycle by the assertions. The convert strobe and the shift clock are never high together, and the pulse count never passes the mode's limit. Valid and error never occur together, and each lasts only one cycle. The result word moves only when a finished frame is reported.

Other behaviour shows only in the bench's scenarios. These are that the assembled word matches the bits a modelled converter launched in either mode, and that the exact pulse counts hold. They also include the discarding of words with corrupted headers, the hold-off of a request that stays asserted, and the clearing done by a reset in the middle of a burst.

// File: rtl/adc_rx_pkg.sv
package adc_rx_pkg;
  typedef struct packed {
    logic clear;       // start of a conversion: empty the shift register
    logic sampleSelf;  // self-clocked mode: take the data line now
    logic finish;      // burst over: judge and report the frame
  } rxStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CNV,
    ST_WAIT,
    ST_SHIFT,
    ST_DONE
  } rxState_t;
endpackage

// File: rtl/adc_rx_ctrl.sv
module adc_rx_ctrl
  import adc_rx_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int HDR_W     = 2,
  parameter int CNV_HIGH  = 2,
  parameter int CONV_WAIT = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      modeSelf,
  input  logic      convReq,
  output logic      cnvOut,
  output logic      sclkOut,
  output rxStrobe_t strobe
);
  localparam int FRAME_W  = DATA_W + HDR_W;
  localparam int TMR_MAX  = (CNV_HIGH > CONV_WAIT) ? CNV_HIGH : CONV_WAIT;
  localparam int TMR_W    = $clog2(TMR_MAX + 1);
  localparam int PLS_W    = $clog2(FRAME_W + 1);

  rxState_t          state;
  logic [TMR_W-1:0]  timer;
  logic [PLS_W-1:0]  pulses;
  logic [PLS_W-1:0]  target;
  logic              phase;

  assign target = modeSelf ? PLS_W'(FRAME_W) : PLS_W'(DATA_W);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      timer   <= '0;
      pulses  <= '0;
      phase   <= 1'b0;
      cnvOut  <= 1'b0;
      sclkOut <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (convReq) begin
            state  <= ST_CNV;
            cnvOut <= 1'b1;
            timer  <= TMR_W'(CNV_HIGH - 1);
          end
        end
        ST_CNV: begin
          if (timer == '0) begin
            cnvOut <= 1'b0;
            state  <= ST_WAIT;
            timer  <= TMR_W'(CONV_WAIT - 1);
          end else begin
            timer <= timer - 1'b1;
          end
        end
        ST_WAIT: begin
          if (timer == '0) begin
            state  <= ST_SHIFT;
            phase  <= 1'b0;
            pulses <= '0;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        ST_SHIFT: begin
          if (!phase) begin
            if (pulses == target) begin
              state <= ST_DONE;
            end else begin
              sclkOut <= 1'b1;
              phase   <= 1'b1;
            end
          end else begin
            sclkOut <= 1'b0;
            phase   <= 1'b0;
            pulses  <= pulses + 1'b1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.clear      = (state == ST_IDLE) && convReq;
    strobe.sampleSelf = (state == ST_SHIFT) && modeSelf && !phase && (pulses != '0);
    strobe.finish     = (state == ST_DONE);
  end

  // R1 / R2: no shift clock while the convert strobe is high
  p_cnv_sclk_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    cnvOut |-> !sclkOut);

  // R2: the burst never exceeds the pulse count of the mode
  p_pulse_limit_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT) |-> (pulses <= target));

  // R2: each shift pulse is high for a single cycle
  p_sclk_single_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    sclkOut |=> !sclkOut);

  // R1: a new strobe only rises out of idle
  p_cnv_from_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cnvOut) |-> $past(state == ST_IDLE));
endmodule

// File: rtl/adc_rx_dpath.sv
module adc_rx_dpath
  import adc_rx_pkg::*;
#(
  parameter int               DATA_W  = 16,
  parameter int               HDR_W   = 2,
  parameter logic [HDR_W-1:0] HDR_PAT = 2'b10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSelf,
  input  logic              serData,
  input  logic              echoClk,
  input  rxStrobe_t         strobe,
  output logic [DATA_W-1:0] resultWord,
  output logic              resultValid,
  output logic              frameErr
);
  localparam int FRAME_W = DATA_W + HDR_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] shiftQ;
  logic [CNT_W-1:0]   bitCnt;
  logic [CNT_W-1:0]   expCnt;
  logic               echoPrev;
  logic               echoRise;
  logic               take;
  logic               hdrOk;
  logic               frameOk;

  assign echoRise = !modeSelf && echoClk && !echoPrev;
  assign take     = strobe.sampleSelf || echoRise;
  assign expCnt   = modeSelf ? FRAME_CNT : CNT_W'(DATA_W);
  assign hdrOk    = !modeSelf || (shiftQ[FRAME_W-1 -: HDR_W] == HDR_PAT);
  assign frameOk  = hdrOk && (bitCnt == expCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ      <= '0;
      bitCnt      <= '0;
      echoPrev    <= 1'b0;
      resultWord  <= '0;
      resultValid <= 1'b0;
      frameErr    <= 1'b0;
    end else begin
      echoPrev    <= echoClk;
      resultValid <= 1'b0;
      frameErr    <= 1'b0;
      if (strobe.clear) begin
        shiftQ <= '0;
        bitCnt <= '0;
      end else if (take && (bitCnt != FRAME_CNT)) begin
        shiftQ <= {shiftQ[FRAME_W-2:0], serData};
        bitCnt <= bitCnt + 1'b1;
      end
      if (strobe.finish) begin
        if (frameOk) begin
          resultWord  <= shiftQ[DATA_W-1:0];
          resultValid <= 1'b1;
        end else begin
          frameErr <= 1'b1;
        end
      end
    end
  end

  // R5: valid lasts one cycle
  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R6: error lasts one cycle and never coincides with valid
  p_err_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr);
  p_valid_err_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(resultValid && frameErr));

  // R5: the word only moves when the control reports the end of a burst
  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finish |=> $stable(resultWord));

  // R3: the bit counter stays within one frame
  p_bitcnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FRAME_CNT);
endmodule

// File: rtl/adc_frame_rx.sv
module adc_frame_rx
  import adc_rx_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int HDR_W     = 2,
  parameter int CNV_HIGH  = 2,
  parameter int CONV_WAIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSelf,
  input  logic              convReq,
  input  logic              serData,
  input  logic              echoClk,
  output logic              cnvOut,
  output logic              sclkOut,
  output logic [DATA_W-1:0] resultWord,
  output logic              resultValid,
  output logic              frameErr
);
  rxStrobe_t strobe;

  adc_rx_ctrl #(
    .DATA_W(DATA_W), .HDR_W(HDR_W), .CNV_HIGH(CNV_HIGH), .CONV_WAIT(CONV_WAIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .modeSelf(modeSelf), .convReq(convReq),
    .cnvOut(cnvOut), .sclkOut(sclkOut), .strobe(strobe)
  );

  adc_rx_dpath #(
    .DATA_W(DATA_W), .HDR_W(HDR_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .modeSelf(modeSelf), .serData(serData),
    .echoClk(echoClk), .strobe(strobe), .resultWord(resultWord),
    .resultValid(resultValid), .frameErr(frameErr)
  );
endmodule

// File: tb/adc_frame_rx_bench.sv
`timescale 1ns/1ps
module adc_frame_rx_bench;
  localparam int CNV_HIGH  = 2;
  localparam int CONV_WAIT = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeSelf = 1'b1;
  logic        convReq = 1'b0;
  logic        serData = 1'b0;
  logic        echoClk;
  logic        cnvOut, sclkOut, resultValid, frameErr;
  logic [15:0] resultWord;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;
  assign echoClk = sclkOut;

  adc_frame_rx #(.CNV_HIGH(CNV_HIGH), .CONV_WAIT(CONV_WAIT)) u_adc_frame_rx (
    .clk(clk), .rstN(rstN), .modeSelf(modeSelf), .convReq(convReq),
    .serData(serData), .echoClk(echoClk), .cnvOut(cnvOut), .sclkOut(sclkOut),
    .resultWord(resultWord), .resultValid(resultValid), .frameErr(frameErr)
  );

  // converter model: frame bits sent first bit first
  logic [18:0] fbits = '0;
  int          flen  = 16;
  int          idx   = 0;

  always @(posedge cnvOut) begin
    idx = 0;
    serData <= fbits[flen-1];
  end
  always @(negedge sclkOut) begin
    idx = idx + 1;
    serData <= (idx < flen) ? fbits[flen-1-idx] : 1'b0;
  end

  // port monitor, sampled away from the active edge
  int   sRise = 0, sLong = 0, cRise = 0, cHigh = 0, overlap = 0;
  logic prevS = 1'b0, prevC = 1'b0;
  always @(negedge clk) begin
    if (sclkOut === 1'b1 && prevS === 1'b0) sRise++;
    if (sclkOut === 1'b1 && prevS === 1'b1) sLong++;
    if (cnvOut === 1'b1 && prevC === 1'b0) cRise++;
    if (cnvOut === 1'b1) cHigh++;
    if (cnvOut === 1'b1 && sclkOut === 1'b1) overlap++;
    prevS = sclkOut;
    prevC = cnvOut;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [18:0] buildFrame(input bit selfMode, input logic [15:0] d, input logic [1:0] hdr);
    return selfMode ? {1'b0, hdr, d} : {3'b000, d};
  endfunction

  function automatic int pulsesFor(input bit selfMode);
    return selfMode ? 18 : 16;
  endfunction

  logic [15:0] lastGood = '0;

  task automatic clearMon();
    sRise = 0; sLong = 0; cRise = 0; cHigh = 0; overlap = 0;
  endtask

  task automatic waitDone(output bit seen);
    seen = 1'b0;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      if (resultValid || frameErr) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  task automatic runFrame(input logic [15:0] d, input logic [1:0] hdr, input bit expErr, input bit holdReq);
    bit seen;
    string dreq;
    dreq = modeSelf ? "R3" : "R4";
    fbits = buildFrame(modeSelf, d, hdr);
    flen  = modeSelf ? 19 : 16;
    @(negedge clk);
    clearMon();
    convReq = 1'b1;
    if (!holdReq) begin
      @(negedge clk);
      convReq = 1'b0;
    end
    waitDone(seen);
    convReq = 1'b0;
    chk(seen, "R5 frame completion", 32'(seen), 32'd1);
    if (expErr) begin
      chk(frameErr && !resultValid, "R6 error pulse", {resultValid, frameErr}, 32'b01);
      chk(resultWord == lastGood, "R6 word kept", resultWord, lastGood);
    end else begin
      chk(resultValid && !frameErr, "R5 valid pulse", {resultValid, frameErr}, 32'b10);
      chk(resultWord == d, dreq, resultWord, d);
      lastGood = d;
    end
    chk(sRise == pulsesFor(modeSelf), "R2 pulse count", sRise, pulsesFor(modeSelf));
    chk(sLong == 0 && overlap == 0, "R2 pulse shape", {sLong[15:0], overlap[15:0]}, 32'd0);
    chk(cRise == 1 && cHigh == CNV_HIGH, "R1 strobe", {cRise[15:0], cHigh[15:0]}, {16'd1, 16'(CNV_HIGH)});
    @(negedge clk);
    chk(!resultValid && !frameErr, "R5 single-cycle report", {resultValid, frameErr}, 32'd0);
    chk(resultWord == lastGood, "R5 word holds", resultWord, lastGood);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk(!cnvOut && !sclkOut && !resultValid && !frameErr && resultWord == 16'h0, "R7 reset state",
        {cnvOut, sclkOut, resultValid, frameErr, resultWord}, 32'd0);
    rstN = 1'b1;
    lastGood = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    logic [15:0] dirList [5];
    seed = $urandom(32'd4711);
    dirList[0] = 16'h0000; dirList[1] = 16'hFFFF; dirList[2] = 16'h8000;
    dirList[3] = 16'h7FFF; dirList[4] = 16'hA5A5;

    doReset();  // R7

    // self-clocked mode: R3, header errors R6
    modeSelf = 1'b1;
    foreach (dirList[i]) runFrame(dirList[i], 2'b10, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) runFrame(16'($urandom), 2'b10, 1'b0, 1'b0);
    runFrame(16'h1234, 2'b11, 1'b1, 1'b0);  // R6: 0 after the 1 is wrong
    runFrame(16'h4321, 2'b00, 1'b1, 1'b0);  // R6: missing 1
    runFrame(16'hBEEF, 2'b01, 1'b1, 1'b0);  // R6: header shifted
    runFrame(16'h0F0F, 2'b10, 1'b0, 1'b1);  // R1: request held through the burst

    // echoed-clock mode: R4
    modeSelf = 1'b0;
    foreach (dirList[i]) runFrame(dirList[i], 2'b10, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) runFrame(16'($urandom), 2'b10, 1'b0, 1'b0);
    runFrame(16'h5AA5, 2'b10, 1'b0, 1'b1);  // R1 in echoed-clock mode

    // R7: reset in the middle of a burst
    modeSelf = 1'b1;
    fbits = buildFrame(1'b1, 16'hC3C3, 2'b10);
    flen = 19;
    @(negedge clk);
    convReq = 1'b1;
    @(negedge clk);
    convReq = 1'b0;
    repeat (20) @(negedge clk);
    doReset();
    runFrame(16'h2468, 2'b10, 1'b0, 1'b0);  // clean frame after the reset

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule